// File: doc/BRIEF.md
# Gamepad Serial Protocol Responder

This block is the pad end of a synchronous, full-duplex, byte-serial gamepad link. The host pulls an active-low select line low, clocks a serial clock that idles high, and shifts command bytes in on one line. Over the same clock cycles the block shifts response bytes back on a data line. The block works out which command each frame carries. It replies with its identity, a fixed marker byte, the button and stick values from its parallel inputs, or a configuration reply. It also keeps a small amount of state: the current mode, the selected base mode, the lock flag, the motor-mapping bytes and the two motor outputs.

The host lines are brought into the system clock domain through a short synchronizer. Their edges are detected there. A serial link module shifts the bits. A reply multiplexer picks the outgoing byte for the current byte slot. A mode state machine updates its state only when a frame has finished, and only if the frame ran to its full length. It has three states: ST_DIGITAL, ST_ANALOG and ST_CONFIG. The transitions are:
- ENTER_CFG, from either normal state to ST_CONFIG.
- EXIT_CFG, from ST_CONFIG to the base mode, which is either ST_DIGITAL or ST_ANALOG.

Bytes are numbered from 0 within each frame.

Top module: `pad_responder`

## Requirements
- R1: Bits travel least significant bit first. The pad changes `pad_dat` after each falling edge of `pad_sclk` and samples `pad_cmd` on each rising edge. `pad_dat` is 1 whenever `pad_sel_n` is high.
- R2: The response in byte 0 is 0xFF. Byte 1 carries the identity: 0x41 in ST_DIGITAL, 0x73 in ST_ANALOG and 0xF3 in ST_CONFIG. Byte 2 is 0x5A.
- R3: A frame is 5 bytes long in ST_DIGITAL and 9 bytes long otherwise. Any byte the host clocks beyond that length returns 0xFF.
- R4: If host byte 0 is not 0x01, every response byte in the frame is 0xFF and the frame changes no state.
- R5: The poll response carries buttons[7:0] in byte 3 and buttons[15:8] in byte 4. Bytes 5 to 8 carry stick[7:0], stick[15:8], stick[23:16] and stick[31:24], in that order.
- R6: ENTER_CFG happens when, in ST_DIGITAL or ST_ANALOG, command 0x43 arrives with host byte 3 equal to 0x01. That frame returns the poll response.
- R7: EXIT_CFG happens when, in ST_CONFIG, command 0x43 arrives with host byte 3 equal to 0x00. The state goes to the base mode. In ST_CONFIG, command 0x43 returns 0x00 in bytes 3 to 8.
- R8: Command 0x44 in ST_CONFIG sets the base mode: analog if host byte 3 is 0x01, digital otherwise. It sets the lock flag if host byte 4 is 0x03 and clears it otherwise. It returns 0x00 in bytes 3 to 8.
- R9: Command 0x45 in ST_CONFIG returns, in bytes 3 to 8: 0x03, 0x02, the base-mode byte (0x01 analog, 0x00 digital), the lock byte (0x01 locked, 0x00 not), 0x01 and 0x00.
- R10: Command 0x4D in ST_CONFIG stores host bytes 3 and 4 as the mapping bytes. It returns the previously stored mapping in bytes 3 and 4 and 0xFF in bytes 5 to 8.
- R11: A completed command 0x42 updates the motor outputs, and nothing else does. If the mapping is 0x00, 0x01, then `motor_small` becomes (host byte 3 == 0x01) and `motor_large` becomes host byte 4. Otherwise both are cleared.
- R12: State changes take effect when `pad_sel_n` rises, and only if the frame reached its full length. A shorter frame is discarded.
- R13: Commands 0x44, 0x45 and 0x4D outside ST_CONFIG, and any other unknown code in any state, get the poll response and change nothing.
- R14: After reset the block is in ST_DIGITAL with base mode digital and the lock clear. The mapping is 0xFF, 0xFF, the motors are off and `pad_dat` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_sel_n | input | 1 | Host select, active low |
| pad_sclk | input | 1 | Host serial clock, idles high |
| pad_cmd | input | 1 | Command bits from the host |
| pad_dat | output | 1 | Response bits to the host |
| buttons | input | 16 | Button states returned in poll bytes 3 and 4 |
| stick | input | 32 | Four stick axis bytes returned in poll bytes 5 to 8 |
| motor_small | output | 1 | Small motor on |
| motor_large | output | 8 | Large motor level |

## Verification
The bench drives the link with asymmetric button bytes, so a pad that sends the most significant bit first returns a bit-reversed value. It runs a digital poll one byte past the 5-byte limit to catch a frame length taken from the wrong mode. It cuts frames short, both an exit-configuration frame and a motor poll, and then shows that the mode and the motors did not move, which exposes a design that commits changes byte by byte. It sends a mode-setting command outside configuration, a frame with a bad start byte, and a mapping command issued twice, so that it can catch wrongly accepted commands and a mapping reply that echoes the new value instead of returning the old one.

// File: rtl/pad_pkg.sv
package pad_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [1:0] {
        ST_DIGITAL = 2'd0,
        ST_ANALOG  = 2'd1,
        ST_CONFIG  = 2'd2
    } pad_mode_e;

    localparam logic [7:0] BYTE_START  = 8'h01;
    localparam logic [7:0] BYTE_MARK   = 8'h5A;
    localparam logic [7:0] BYTE_FILL   = 8'hFF;
    localparam logic [7:0] BYTE_MODEL  = 8'h03;
    localparam logic [7:0] OP_POLL     = 8'h42;
    localparam logic [7:0] OP_CFG      = 8'h43;
    localparam logic [7:0] OP_SETMODE  = 8'h44;
    localparam logic [7:0] OP_QUERY    = 8'h45;
    localparam logic [7:0] OP_MAP      = 8'h4D;
    localparam logic [7:0] ID_DIGITAL  = 8'h41;
    localparam logic [7:0] ID_ANALOG   = 8'h73;
    localparam logic [7:0] ID_CONFIG   = 8'hF3;
    localparam logic [IDX_W-1:0] LEN_SHORT = 4'd5;
    localparam logic [IDX_W-1:0] LEN_LONG  = 4'd9;

    function automatic logic [IDX_W-1:0] frame_len(input pad_mode_e m);
        return (m == ST_DIGITAL) ? LEN_SHORT : LEN_LONG;
    endfunction

    function automatic logic [7:0] ident(input pad_mode_e m);
        unique case (m)
            ST_DIGITAL: return ID_DIGITAL;
            ST_ANALOG:  return ID_ANALOG;
            default:    return ID_CONFIG;
        endcase
    endfunction
endpackage

// File: rtl/pad_serial_link.sv
module pad_serial_link
    import pad_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_in,
    input  logic             sclk_in,
    input  logic             cmd_in,
    input  logic [7:0]       reply_byte,
    output logic             dat_out,
    output logic             sel_s,
    output logic [IDX_W-1:0] byte_idx,
    output logic [IDX_W-1:0] done_idx,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic             frame_end
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [SYNC_DEPTH-1:0] sel_sr, sclk_sr, cmd_sr;
    logic sclk_s, cmd_s, sclk_p, sel_p;
    logic [2:0] bit_cnt;
    logic [7:0] tx_sh;
    logic fall, rise;

    assign sel_s  = sel_sr[SYNC_DEPTH-1];
    assign sclk_s = sclk_sr[SYNC_DEPTH-1];
    assign cmd_s  = cmd_sr[SYNC_DEPTH-1];
    assign fall   = sclk_p & ~sclk_s;
    assign rise   = ~sclk_p & sclk_s;
    assign frame_end = sel_s & ~sel_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_sr  <= '1;
            sclk_sr <= '1;
            cmd_sr  <= '1;
        end else begin
            sel_sr  <= {sel_sr[SYNC_DEPTH-2:0], sel_n_in};
            sclk_sr <= {sclk_sr[SYNC_DEPTH-2:0], sclk_in};
            cmd_sr  <= {cmd_sr[SYNC_DEPTH-2:0], cmd_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p    <= 1'b1;
            sel_p     <= 1'b1;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            done_idx  <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
            tx_sh     <= '1;
            dat_out   <= 1'b1;
        end else begin
            sclk_p    <= sclk_s;
            sel_p     <= sel_s;
            byte_done <= 1'b0;
            if (sel_s) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
                dat_out  <= 1'b1;
            end else begin
                if (fall) begin
                    if (bit_cnt == 3'd0) begin
                        dat_out <= reply_byte[0];
                        tx_sh   <= {1'b1, reply_byte[7:1]};
                    end else begin
                        dat_out <= tx_sh[0];
                        tx_sh   <= {1'b1, tx_sh[7:1]};
                    end
                end
                if (rise) begin
                    rx_byte <= {cmd_s, rx_byte[7:1]};
                    if (bit_cnt == 3'd7) begin
                        bit_cnt   <= '0;
                        byte_done <= 1'b1;
                        done_idx  <= byte_idx;
                        if (byte_idx != IDX_MAX)
                            byte_idx <= byte_idx + 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pad_mode_fsm.sv
module pad_mode_fsm
    import pad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_done,
    input  logic [IDX_W-1:0] done_idx,
    input  logic [7:0]       rx_byte,
    input  logic             frame_end,
    input  logic [IDX_W-1:0] end_idx,
    output pad_mode_e        mode,
    output logic             base_analog,
    output logic             locked,
    output logic [7:0]       map0,
    output logic [7:0]       map1,
    output logic [7:0]       cmd_q,
    output logic             addressed,
    output logic             motor_small,
    output logic [7:0]       motor_large
);
    logic [7:0] arg0, arg1;
    logic commit, map_en;
    pad_mode_e mode_nx;

    assign commit = frame_end && addressed && (end_idx >= frame_len(mode));
    assign map_en = (map0 == 8'h00) && (map1 == 8'h01);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= ST_DIGITAL;
        else        mode <= mode_nx;
    end

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            ST_DIGITAL, ST_ANALOG: begin
                if (commit && cmd_q == OP_CFG && arg0 == 8'h01)
                    mode_nx = ST_CONFIG;
            end
            ST_CONFIG: begin
                if (commit && cmd_q == OP_CFG && arg0 == 8'h00)
                    mode_nx = base_analog ? ST_ANALOG : ST_DIGITAL;
            end
            default: mode_nx = ST_DIGITAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_analog <= 1'b0;
            locked      <= 1'b0;
            map0        <= 8'hFF;
            map1        <= 8'hFF;
            cmd_q       <= 8'h00;
            arg0        <= 8'h00;
            arg1        <= 8'h00;
            addressed   <= 1'b0;
            motor_small <= 1'b0;
            motor_large <= 8'h00;
        end else begin
            if (byte_done) begin
                unique case (done_idx)
                    4'd0:    addressed <= (rx_byte == BYTE_START);
                    4'd1:    cmd_q <= rx_byte;
                    4'd3:    arg0 <= rx_byte;
                    4'd4:    arg1 <= rx_byte;
                    default: ;
                endcase
            end
            if (frame_end) addressed <= 1'b0;
            if (commit) begin
                if (cmd_q == OP_POLL) begin
                    motor_small <= map_en && (arg0 == 8'h01);
                    motor_large <= map_en ? arg1 : 8'h00;
                end
                if (mode == ST_CONFIG && cmd_q == OP_SETMODE) begin
                    base_analog <= (arg0 == 8'h01);
                    locked      <= (arg1 == 8'h03);
                end
                if (mode == ST_CONFIG && cmd_q == OP_MAP) begin
                    map0 <= arg0;
                    map1 <= arg1;
                end
            end
        end
    end
endmodule

// File: rtl/pad_reply_mux.sv
module pad_reply_mux
    import pad_pkg::*;
(
    input  pad_mode_e        mode,
    input  logic             base_analog,
    input  logic             locked,
    input  logic [7:0]       map0,
    input  logic [7:0]       map1,
    input  logic [7:0]       cmd_q,
    input  logic             addressed,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [15:0]      buttons,
    input  logic [31:0]      stick,
    output logic [7:0]       reply_byte
);
    logic cfg;
    logic [IDX_W-1:0] rel;

    assign cfg = (mode == ST_CONFIG);
    assign rel = byte_idx - 4'd5;

    always_comb begin
        reply_byte = BYTE_FILL;
        if (byte_idx == 4'd0 || !addressed || byte_idx >= frame_len(mode)) begin
            reply_byte = BYTE_FILL;
        end else if (byte_idx == 4'd1) begin
            reply_byte = ident(mode);
        end else if (byte_idx == 4'd2) begin
            reply_byte = BYTE_MARK;
        end else if (cfg && (cmd_q == OP_CFG || cmd_q == OP_SETMODE)) begin
            reply_byte = 8'h00;
        end else if (cfg && cmd_q == OP_QUERY) begin
            unique case (byte_idx)
                4'd3:    reply_byte = BYTE_MODEL;
                4'd4:    reply_byte = 8'h02;
                4'd5:    reply_byte = {7'd0, base_analog};
                4'd6:    reply_byte = {7'd0, locked};
                4'd7:    reply_byte = 8'h01;
                default: reply_byte = 8'h00;
            endcase
        end else if (cfg && cmd_q == OP_MAP) begin
            if (byte_idx == 4'd3)      reply_byte = map0;
            else if (byte_idx == 4'd4) reply_byte = map1;
            else                       reply_byte = BYTE_FILL;
        end else begin
            if (byte_idx == 4'd3)      reply_byte = buttons[7:0];
            else if (byte_idx == 4'd4) reply_byte = buttons[15:8];
            else                       reply_byte = stick[{rel[1:0], 3'b000} +: 8];
        end
    end
endmodule

// File: rtl/pad_responder.sv
module pad_responder
    import pad_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pad_sel_n,
    input  logic        pad_sclk,
    input  logic        pad_cmd,
    output logic        pad_dat,
    input  logic [15:0] buttons,
    input  logic [31:0] stick,
    output logic        motor_small,
    output logic [7:0]  motor_large
);
    logic             sel_s, byte_done, frame_end, addressed;
    logic             base_analog, locked;
    logic [IDX_W-1:0] byte_idx, done_idx;
    logic [7:0]       rx_byte, reply_byte, map0, map1, cmd_q;
    pad_mode_e        mode;

    pad_serial_link #(.SYNC_DEPTH(SYNC_DEPTH)) u_link (
        .clk(clk), .rst_n(rst_n),
        .sel_n_in(pad_sel_n), .sclk_in(pad_sclk), .cmd_in(pad_cmd),
        .reply_byte(reply_byte), .dat_out(pad_dat), .sel_s(sel_s),
        .byte_idx(byte_idx), .done_idx(done_idx), .byte_done(byte_done),
        .rx_byte(rx_byte), .frame_end(frame_end)
    );

    pad_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .byte_done(byte_done), .done_idx(done_idx), .rx_byte(rx_byte),
        .frame_end(frame_end), .end_idx(byte_idx),
        .mode(mode), .base_analog(base_analog), .locked(locked),
        .map0(map0), .map1(map1), .cmd_q(cmd_q), .addressed(addressed),
        .motor_small(motor_small), .motor_large(motor_large)
    );

    pad_reply_mux u_mux (
        .mode(mode), .base_analog(base_analog), .locked(locked),
        .map0(map0), .map1(map1), .cmd_q(cmd_q), .addressed(addressed),
        .byte_idx(byte_idx), .buttons(buttons), .stick(stick),
        .reply_byte(reply_byte)
    );
endmodule

// File: rtl/pad_responder_chk.sv
module pad_responder_chk
    import pad_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_s,
    input logic       pad_dat,
    input logic       frame_end,
    input logic       byte_done,
    input logic       motor_small,
    input logic [7:0] motor_large,
    input pad_mode_e  mode
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> pad_dat);

    assert_byte_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_motor_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(motor_small) && $stable(motor_large)));

    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(mode));

    assert_enter_via_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ST_CONFIG) |=> (mode == $past(mode) || mode == ST_CONFIG));
endmodule

bind pad_responder pad_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .pad_dat(pad_dat),
    .frame_end(frame_end), .byte_done(byte_done),
    .motor_small(motor_small), .motor_large(motor_large), .mode(mode)
);

// File: tb/tb_pad_responder.sv
module tb_pad_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_sel_n = 1'b1;
    logic        pad_sclk = 1'b1;
    logic        pad_cmd = 1'b1;
    logic        pad_dat;
    logic [15:0] buttons = 16'hC31E;
    logic [31:0] stick = 32'h44332211;
    logic        motor_small;
    logic [7:0]  motor_large;

    logic [7:0] tx [0:8];
    logic [7:0] rx [0:8];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pad_responder dut (
        .clk(clk), .rst_n(rst_n), .pad_sel_n(pad_sel_n), .pad_sclk(pad_sclk),
        .pad_cmd(pad_cmd), .pad_dat(pad_dat), .buttons(buttons), .stick(stick),
        .motor_small(motor_small), .motor_large(motor_large)
    );

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic set_tx(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7, b8);
        tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3; tx[4] = b4;
        tx[5] = b5; tx[6] = b6; tx[7] = b7; tx[8] = b8;
    endtask

    task automatic run_frame(input int n);
        pad_sel_n = 1'b0;
        half();
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 8; i++) begin
                pad_sclk = 1'b0;
                pad_cmd  = tx[b][i];
                half();
                rx[b][i] = pad_dat;
                pad_sclk = 1'b1;
                half();
            end
        end
        pad_cmd   = 1'b1;
        pad_sel_n = 1'b1;
        half();
        half();
    endtask

    task automatic poll_id(input string req, input logic [7:0] exp_id);
        set_tx(8'h01, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(3);
        chk(req, rx[1], exp_id);
    endtask

    task automatic t_reset();
        chk("R14 dat idle", {7'd0, pad_dat}, 8'h01);
        chk("R14 small motor", {7'd0, motor_small}, 8'h00);
        chk("R14 large motor", motor_large, 8'h00);
    endtask

    task automatic t_digital_poll();
        set_tx(8'h01, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(6);
        chk("R2 byte0", rx[0], 8'hFF);
        chk("R2 digital id", rx[1], 8'h41);
        chk("R2 marker", rx[2], 8'h5A);
        chk("R5 R1 buttons low lsb-first", rx[3], 8'h1E);
        chk("R5 buttons high", rx[4], 8'hC3);
        chk("R3 beyond short frame", rx[5], 8'hFF);
        chk("R1 idle after frame", {7'd0, pad_dat}, 8'h01);
    endtask

    task automatic t_not_addressed();
        set_tx(8'h02, 8'h43, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(5);
        chk("R4 id slot", rx[1], 8'hFF);
        chk("R4 marker slot", rx[2], 8'hFF);
        chk("R4 data slot", rx[3], 8'hFF);
        poll_id("R4 no mode change", 8'h41);
    endtask

    task automatic t_motor_unmapped();
        set_tx(8'h01, 8'h42, 8'h00, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(5);
        chk("R11 unmapped small", {7'd0, motor_small}, 8'h00);
        chk("R11 unmapped large", motor_large, 8'h00);
    endtask

    task automatic t_enter_cfg();
        set_tx(8'h01, 8'h43, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(5);
        chk("R6 enter reply id", rx[1], 8'h41);
        chk("R6 enter reply poll data", rx[3], 8'h1E);
        set_tx(8'h01, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R6 config id", rx[1], 8'hF3);
        chk("R3 R5 long frame stick byte", rx[8], 8'h44);
        chk("R5 first stick byte", rx[5], 8'h11);
    endtask

    task automatic t_query(input logic [7:0] exp_mode, input logic [7:0] exp_lock);
        set_tx(8'h01, 8'h45, 8'h00, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A);
        run_frame(9);
        chk("R9 model", rx[3], 8'h03);
        chk("R9 fixed 02", rx[4], 8'h02);
        chk("R9 R8 mode byte", rx[5], exp_mode);
        chk("R9 R8 lock byte", rx[6], exp_lock);
        chk("R9 fixed 01", rx[7], 8'h01);
        chk("R9 fixed 00", rx[8], 8'h00);
    endtask

    task automatic t_setmode();
        set_tx(8'h01, 8'h44, 8'h00, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R8 reply byte3", rx[3], 8'h00);
        chk("R8 reply byte8", rx[8], 8'h00);
        chk("R8 still config", rx[1], 8'hF3);
    endtask

    task automatic t_map();
        set_tx(8'h01, 8'h4D, 8'h00, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(9);
        chk("R10 old map0 reset", rx[3], 8'hFF);
        chk("R10 old map1 reset", rx[4], 8'hFF);
        chk("R10 filler", rx[5], 8'hFF);
        run_frame(9);
        chk("R10 previous map0", rx[3], 8'h00);
        chk("R10 previous map1", rx[4], 8'h01);
        chk("R10 filler again", rx[7], 8'hFF);
    endtask

    task automatic t_partial_exit();
        set_tx(8'h01, 8'h43, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(4);
        poll_id("R12 partial exit ignored", 8'hF3);
    endtask

    task automatic t_exit();
        set_tx(8'h01, 8'h43, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R7 exit byte3 zero", rx[3], 8'h00);
        chk("R7 exit byte8 zero", rx[8], 8'h00);
        set_tx(8'h01, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R7 analog id after exit", rx[1], 8'h73);
        chk("R3 analog long frame", rx[7], 8'h33);
    endtask

    task automatic t_motors();
        set_tx(8'h01, 8'h42, 8'h00, 8'h01, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R11 small on", {7'd0, motor_small}, 8'h01);
        chk("R11 large level", motor_large, 8'hC3);
        set_tx(8'h01, 8'h42, 8'h00, 8'h00, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(5);
        chk("R12 partial poll small held", {7'd0, motor_small}, 8'h01);
        chk("R12 partial poll large held", motor_large, 8'hC3);
        run_frame(9);
        chk("R11 small off", {7'd0, motor_small}, 8'h00);
        chk("R11 large new", motor_large, 8'h55);
    endtask

    task automatic t_unknown();
        set_tx(8'h01, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R13 setmode outside config id", rx[1], 8'h73);
        chk("R13 setmode outside config poll", rx[3], 8'h1E);
        set_tx(8'h01, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_frame(9);
        chk("R13 unknown code poll data", rx[4], 8'hC3);
        chk("R13 large motor untouched", motor_large, 8'h55);
        poll_id("R13 mode unchanged", 8'h73);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_digital_poll();
        t_not_addressed();
        t_motor_unmapped();
        t_enter_cfg();
        t_query(8'h00, 8'h00);
        t_setmode();
        t_query(8'h01, 8'h01);
        t_map();
        t_partial_exit();
        t_exit();
        t_motors();
        t_unknown();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule